// File: doc/BRIEF.md
# Switching-Matrix Host Command Port

This block is the host-facing command port of a time-slot switching matrix. A host processor drives an 8-bit bus, two active-low chip selects, active-low read and write strobes and a command/data qualifier (`cd`). It loads an instruction as a run of data bytes with `cd` low, then commits it with one opcode byte with `cd` high. The port checks the opcode and the byte count, then tests a match condition on the first data byte. From the result it either drops the instruction, rewrites it as a channel disconnection, or passes it as it came. Passed instructions wait for a spare memory cycle before they go to the switch datapath as a one-cycle request.

Two result registers are updated when an instruction completes. The host reads them back with `cd` selecting which one. A ready flag (`dr`) falls when an opcode is rejected as illegal and rises again when an instruction executes. All strobes are brought into the clock domain before use. A read that returns the same register as the previous counted read does not advance the host flow. Strobe overlaps and the few cycles after key events are protected against stray writes.

Top module: `swm_cmd_ctrl`

## Requirements
- R1: An opcode is legal when bits [7:3] are zero and bits [2:0] hold a type from 1 to 6. Types 1 and 3 need exactly 4 data bytes before the opcode and the other types need exactly 2. A legal type with the wrong count is treated as illegal.
- R2: An illegal opcode issues no request, drives `dr` low and leaves both result registers unchanged.
- R3: A legal type 2, 4 or 6 that fails the match issues no request and leaves `dr` at its previous value.
- R4: A legal type 1 or 3 that fails the match executes as a disconnection, which is type 2 on `exec_op` and in the result register.
- R5: A matched legal opcode, or any legal type 5 opcode, executes unchanged. `exec_op` carries its type. `exec_data` carries the data bytes in arrival order starting at bits [31:24], with unused bytes zero. Result register 1 becomes {5'b0, type} and result register 2 becomes the first data byte.
- R6: The match compares the first data byte with `match_ref` on the bits where `match_mask` is 1. Bits where the mask is 0 are ignored.
- R7: When the opcode strobe is released, `exec_valid` rises after exactly 6 rising clock edges if `mem_spare` is held high. It rises after exactly 9 edges if `mem_spare` stays low. This is 2 synchroniser edges, 1 detect edge, 2 validation cycles and a spare-cycle wait of 1 to 4 cycles.
- R8: `dr` is high after reset and rises when an instruction executes.
- R9: While the chip is selected and `rd_n` and `wr_n` are both low, `dout_oe` is low. A write or read whose low phase overlapped the other strobe is ignored.
- R10: `dout` gives result register 1 when `cd`=0 and result register 2 when `cd`=1. `dout_oe` is high while the chip is selected, `rd_n` is low and `wr_n` is high. `rd_step` pulses once for a read of a register other than the one last counted. A repeat of the same register does not pulse. Each completed instruction clears the record, so the next read counts.
- R11: For 3 cycles after an opcode is accepted, or after a counted read of result register 2, write strobes are ignored.
- R12: Strobes given while either chip select is high are ignored.
- R13: Writes that arrive while an instruction is being validated or waits for execution are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = opcode / register 2, 0 = data / register 1 |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Read data bus enable |
| dr | output | 1 | Ready flag, low after an illegal opcode |
| mem_spare | input | 1 | Datapath memory has a spare cycle |
| match_ref | input | 8 | Expected value for the match |
| match_mask | input | 8 | Match mask, 1 = compare bit |
| exec_valid | output | 1 | One-cycle execution request |
| exec_op | output | 3 | Type executed |
| exec_data | output | 32 | Data bytes of the executed instruction |
| rd_step | output | 1 | Pulse per counted host read |

## Verification
A table of instructions covers every type with matching and failing first bytes. It includes full, partial and empty masks, illegal codes and wrong byte counts. Together these separate the four outcomes: dropped with the flag cleared, dropped with the flag kept, rewritten as a disconnection, and executed unchanged. Each vector holds `mem_spare` either high or low, so the measured request latency shows the shortest and the longest wait in the queue. Directed sequences then repeat reads of one register, write during the hold window, during busy execution and while deselected, and overlap the two strobes. Each of these plants a stray byte. Because a stray byte changes the count, the next opcode's outcome shows whether the byte was ignored.

// File: rtl/swm_cmd_pkg.sv
package swm_cmd_pkg;
    localparam int BYTE_W   = 8;
    localparam int SLOT_N   = 4;
    localparam int CNT_W    = 3;
    localparam int HOLD_N   = 3;
    localparam int WAIT_MAX = 4;
    localparam int KIND_W   = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DECODE,
        SQ_MATCH,
        SQ_QUEUE,
        SQ_DONE
    } seq_st_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_OR1,
        RD_OR2
    } rd_tag_t;

    function automatic logic [KIND_W-1:0] op_kind(input logic [BYTE_W-1:0] op);
        return op[KIND_W-1:0];
    endfunction

    function automatic logic op_legal(input logic [BYTE_W-1:0] op);
        return (op[BYTE_W-1:KIND_W] == '0) && (op[KIND_W-1:0] != 3'd0)
            && (op[KIND_W-1:0] != 3'd7);
    endfunction

    function automatic logic [CNT_W-1:0] op_need(input logic [KIND_W-1:0] k);
        return (k == 3'd1 || k == 3'd3) ? CNT_W'(4) : CNT_W'(2);
    endfunction
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: INIT, s2: INIT};
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q.s2;
endmodule

// File: rtl/swm_strobe.sv
module swm_strobe #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic          wr_evt,
    output logic          wr_cd,
    output logic [DW-1:0] wr_byte,
    output logic          rd_evt,
    output logic          rd_cd
);
    typedef struct packed {
        logic          rd_lo;
        logic          wr_lo;
        logic          rd_bad;
        logic          wr_bad;
        logic          wcd;
        logic [DW-1:0] wbyte;
        logic          rcd;
    } strb_t;

    strb_t s_d, s_q;
    logic rd_lo_c, wr_lo_c, clash_c;

    assign rd_lo_c = sel & ~rd_n;
    assign wr_lo_c = sel & ~wr_n;
    assign clash_c = rd_lo_c & wr_lo_c;

    always_comb begin
        s_d        = s_q;
        s_d.rd_lo  = rd_lo_c;
        s_d.wr_lo  = wr_lo_c;
        s_d.wr_bad = wr_lo_c & (s_q.wr_bad | clash_c);
        s_d.rd_bad = rd_lo_c & (s_q.rd_bad | clash_c);
        if (wr_lo_c && !clash_c) begin
            s_d.wbyte = din;
            s_d.wcd   = cd;
        end
        if (rd_lo_c && !clash_c) begin
            s_d.rcd = cd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_evt  = s_q.wr_lo & ~wr_lo_c & ~s_q.wr_bad;
    assign rd_evt  = s_q.rd_lo & ~rd_lo_c & ~s_q.rd_bad;
    assign wr_cd   = s_q.wcd;
    assign wr_byte = s_q.wbyte;
    assign rd_cd   = s_q.rcd;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_evt && rd_evt));
endmodule

// File: rtl/swm_stack.sv
module swm_stack #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic                clear,
    input  logic [DW-1:0]       byte_in,
    output logic [CW-1:0]       cnt,
    output logic [DW-1:0]       head,
    output logic [DEPTH*DW-1:0] flat
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (clear) begin
            k_d = '0;
        end else if (push) begin
            if (k_q.cnt < CW'(DEPTH)) begin
                k_d.slot[k_q.cnt[IDX_W-1:0]] = byte_in;
            end
            if (k_q.cnt != '1) begin
                k_d.cnt = k_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            k_q <= k_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[(DEPTH-1-g)*DW +: DW] = k_q.slot[g];
    end

    assign cnt  = k_q.cnt;
    assign head = k_q.slot[0];

    // R1
    count_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |=> (cnt != '0));
endmodule

// File: rtl/swm_seq.sv
module swm_seq
    import swm_cmd_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              wr_cd,
    input  logic [DW-1:0]     wr_byte,
    input  logic              rd_evt,
    input  logic              rd_cd,
    input  logic              spare,
    input  logic [DW-1:0]     ref_val,
    input  logic [DW-1:0]     ref_mask,
    input  logic [CW-1:0]     stk_cnt,
    input  logic [DW-1:0]     stk_head,
    output logic              push,
    output logic              clear,
    output logic [DW-1:0]     or1,
    output logic [DW-1:0]     or2,
    output logic              dr,
    output logic              exec_v,
    output logic [KIND_W-1:0] exec_op,
    output logic              rd_step
);
    localparam int WW = $clog2(WAIT_MAX);
    localparam int HW = $clog2(HOLD_N + 1);

    typedef struct packed {
        seq_st_t           st;
        logic [DW-1:0]     opc;
        logic              legal;
        logic [KIND_W-1:0] kind;
        logic [KIND_W-1:0] xop;
        logic [WW-1:0]     wcnt;
        logic [HW-1:0]     hold;
        rd_tag_t           last;
        logic [DW-1:0]     or1;
        logic [DW-1:0]     or2;
        logic              dr;
        logic              ev;
        logic              step;
    } seq_t;

    seq_t q_d, q_q;
    logic idle_c, held_c, go_c, hit_c;
    rd_tag_t tag_c;

    assign idle_c = (q_q.st == SQ_IDLE);
    assign held_c = (q_q.hold != '0);
    assign go_c   = wr_evt & wr_cd & idle_c & ~held_c;
    assign push   = wr_evt & ~wr_cd & idle_c & ~held_c;
    assign hit_c  = (((stk_head ^ ref_val) & ref_mask) == '0);
    assign tag_c  = rd_cd ? RD_OR2 : RD_OR1;

    always_comb begin
        q_d      = q_q;
        q_d.ev   = 1'b0;
        q_d.step = 1'b0;
        clear    = 1'b0;
        if (held_c) begin
            q_d.hold = q_q.hold - 1'b1;
        end
        if (rd_evt && (tag_c != q_q.last)) begin
            q_d.step = 1'b1;
            q_d.last = tag_c;
            if (rd_cd) begin
                q_d.hold = HW'(HOLD_N);
            end
        end
        case (q_q.st)
            SQ_IDLE: begin
                if (go_c) begin
                    q_d.st   = SQ_DECODE;
                    q_d.opc  = wr_byte;
                    q_d.hold = HW'(HOLD_N);
                end
            end
            SQ_DECODE: begin
                q_d.kind  = op_kind(q_q.opc);
                q_d.legal = op_legal(q_q.opc) && (stk_cnt == op_need(op_kind(q_q.opc)));
                q_d.st    = SQ_MATCH;
            end
            SQ_MATCH: begin
                q_d.wcnt = '0;
                if (!q_q.legal) begin
                    q_d.dr = 1'b0;
                    clear  = 1'b1;
                    q_d.st = SQ_IDLE;
                end else if (hit_c || q_q.kind == 3'd5) begin
                    q_d.xop = q_q.kind;
                    q_d.st  = SQ_QUEUE;
                end else if (q_q.kind == 3'd1 || q_q.kind == 3'd3) begin
                    q_d.xop = 3'd2;
                    q_d.st  = SQ_QUEUE;
                end else begin
                    clear  = 1'b1;
                    q_d.st = SQ_IDLE;
                end
            end
            SQ_QUEUE: begin
                if (spare || q_q.wcnt == WW'(WAIT_MAX - 1)) begin
                    q_d.st   = SQ_DONE;
                    q_d.ev   = 1'b1;
                    q_d.or1  = {{(DW-KIND_W){1'b0}}, q_q.xop};
                    q_d.or2  = stk_head;
                    q_d.dr   = 1'b1;
                    q_d.last = RD_NONE;
                end else begin
                    q_d.wcnt = q_q.wcnt + 1'b1;
                end
            end
            SQ_DONE: begin
                clear  = 1'b1;
                q_d.st = SQ_IDLE;
            end
            default: q_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q      <= '0;
            q_q.st   <= SQ_IDLE;
            q_q.last <= RD_NONE;
            q_q.dr   <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign or1     = q_q.or1;
    assign or2     = q_q.or2;
    assign dr      = q_q.dr;
    assign exec_v  = q_q.ev;
    assign exec_op = q_q.xop;
    assign rd_step = q_q.step;

    // latency window counter for the checks below
    logic [3:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (go_c) begin
            lat_q <= 4'd1;
        end else if (!idle_c && lat_q != 4'hF) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R7
    exec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_v |-> (lat_q >= 4'd4 && lat_q <= 4'd7));

    // R5
    exec_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_v |-> (exec_op >= 3'd1 && exec_op <= 3'd6));

    // R8
    dr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dr) |-> exec_v);

    // R10
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_step |=> !rd_step);

    // R11
    hold_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && q_q.last == RD_OR2) |-> !push);
endmodule

// File: rtl/swm_cmd_ctrl.sv
module swm_cmd_ctrl
    import swm_cmd_pkg::*;
#(
    parameter int DW    = BYTE_W,
    parameter int DEPTH = SLOT_N,
    parameter int CW    = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_a_n,
    input  logic                cs_b_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic                cd,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       dout,
    output logic                dout_oe,
    output logic                dr,
    input  logic                mem_spare,
    input  logic [DW-1:0]       match_ref,
    input  logic [DW-1:0]       match_mask,
    output logic                exec_valid,
    output logic [KIND_W-1:0]   exec_op,
    output logic [DEPTH*DW-1:0] exec_data,
    output logic                rd_step
);
    localparam int SW = DW + 4;
    localparam logic [SW-1:0] SYNC_INIT = {1'b0, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

    logic          sel_raw;
    logic [SW-1:0] sy;
    logic          wr_evt, wr_cd, rd_evt, rd_cd;
    logic [DW-1:0] wr_byte;
    logic          push, clear;
    logic [CW-1:0] stk_cnt;
    logic [DW-1:0] stk_head, or1, or2;

    assign sel_raw = ~cs_a_n & ~cs_b_n;

    swm_sync #(.W(SW), .INIT(SYNC_INIT)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sel_raw, rd_n, wr_n, cd, din}),
        .q   (sy)
    );

    swm_strobe #(.DW(DW)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sy[DW+3]),
        .rd_n    (sy[DW+2]),
        .wr_n    (sy[DW+1]),
        .cd      (sy[DW]),
        .din     (sy[DW-1:0]),
        .wr_evt  (wr_evt),
        .wr_cd   (wr_cd),
        .wr_byte (wr_byte),
        .rd_evt  (rd_evt),
        .rd_cd   (rd_cd)
    );

    swm_stack #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .clear   (clear),
        .byte_in (wr_byte),
        .cnt     (stk_cnt),
        .head    (stk_head),
        .flat    (exec_data)
    );

    swm_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_evt   (wr_evt),
        .wr_cd    (wr_cd),
        .wr_byte  (wr_byte),
        .rd_evt   (rd_evt),
        .rd_cd    (rd_cd),
        .spare    (mem_spare),
        .ref_val  (match_ref),
        .ref_mask (match_mask),
        .stk_cnt  (stk_cnt),
        .stk_head (stk_head),
        .push     (push),
        .clear    (clear),
        .or1      (or1),
        .or2      (or2),
        .dr       (dr),
        .exec_v   (exec_valid),
        .exec_op  (exec_op),
        .rd_step  (rd_step)
    );

    assign dout    = cd ? or2 : or1;
    assign dout_oe = sel_raw & ~rd_n & wr_n;

    // R13
    busy_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> !push);
endmodule

// File: tb/swm_cmd_ctrl_test.sv
module swm_cmd_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_a_n = 1'b0, cs_b_n = 1'b0;
    logic        rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe, dr, mem_spare = 1'b1;
    logic [7:0]  match_ref = '0, match_mask = '0;
    logic        exec_valid, rd_step;
    logic [2:0]  exec_op;
    logic [31:0] exec_data;

    int n_chk = 0, n_bad = 0, n_step = 0, n_exec = 0;
    logic [2:0]  cap_op;
    logic [31:0] cap_data;
    logic [7:0]  m_or1 = '0, m_or2 = '0;

    always #5 clk = ~clk;

    swm_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .rd_n(rd_n), .wr_n(wr_n), .cd(cd), .din(din), .dout(dout),
        .dout_oe(dout_oe), .dr(dr), .mem_spare(mem_spare),
        .match_ref(match_ref), .match_mask(match_mask),
        .exec_valid(exec_valid), .exec_op(exec_op), .exec_data(exec_data),
        .rd_step(rd_step)
    );

    always @(negedge clk) begin
        if (rd_step) n_step++;
        if (exec_valid) n_exec++;
    end

    typedef struct packed {
        logic [7:0]  op;
        logic [2:0]  nb;
        logic [31:0] bytes;
        logic        spare;
        logic [7:0]  rf;
        logic [7:0]  mk;
        logic        ex;
        logic [2:0]  eop;
        logic        edr;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 3'd2, 32'hA53C0000, 1'b1, 8'h00, 8'hFF, 1'b1, 3'd5, 1'b1, 4'd6},
        '{8'h02, 3'd2, 32'h12340000, 1'b0, 8'h12, 8'hFF, 1'b1, 3'd2, 1'b1, 4'd9},
        '{8'h01, 3'd4, 32'h40112233, 1'b1, 8'h41, 8'h01, 1'b1, 3'd2, 1'b1, 4'd6},
        '{8'h03, 3'd4, 32'hF0010203, 1'b0, 8'h0F, 8'h00, 1'b1, 3'd3, 1'b1, 4'd9},
        '{8'h87, 3'd2, 32'h77880000, 1'b1, 8'h77, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0},
        '{8'h04, 3'd2, 32'h01020000, 1'b1, 8'h02, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0},
        '{8'h06, 3'd2, 32'h66990000, 1'b1, 8'h66, 8'hFF, 1'b1, 3'd6, 1'b1, 4'd6},
        '{8'h01, 3'd2, 32'h10200000, 1'b1, 8'h10, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0},
        '{8'h00, 3'd2, 32'h33440000, 1'b1, 8'h33, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0},
        '{8'h06, 3'd2, 32'h01000000, 1'b1, 8'h02, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0},
        '{8'h02, 3'd2, 32'h5A000000, 1'b1, 8'h5B, 8'hFE, 1'b1, 3'd2, 1'b1, 4'd6},
        '{8'h05, 3'd2, 32'h11220000, 1'b0, 8'h00, 8'hFF, 1'b1, 3'd5, 1'b1, 4'd9},
        '{8'h02, 3'd4, 32'h12000000, 1'b1, 8'h12, 8'hFF, 1'b0, 3'd0, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic c, input logic [7:0] b, input logic selb, input int gap);
        @(negedge clk);
        cs_b_n = ~selb; cd = c; din = b; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; cs_b_n = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_read(input logic c, output logic [7:0] val, output logic oe, input int gap);
        @(negedge clk);
        cd = c; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        val = dout; oe = dout_oe;
        rd_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_exec(output int lat);
        lat = 0;
        for (int k = 1; k <= 14; k++) begin
            @(posedge clk); @(negedge clk);
            if (exec_valid && lat == 0) begin
                lat = k; cap_op = exec_op; cap_data = exec_data;
            end
        end
    endtask

    task automatic read_both(input string req);
        logic [7:0] v; logic oe;
        do_read(1'b0, v, oe, 4);
        chk({req, " OR1 R10"}, {24'b0, v}, {24'b0, m_or1});
        chk("R10 dout_oe during read", {31'b0, oe}, 32'd1);
        do_read(1'b1, v, oe, 4);
        chk({req, " OR2 R10"}, {24'b0, v}, {24'b0, m_or2});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat, s0, e0;
        logic [7:0] v; logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 dr after reset", {31'b0, dr}, 32'd1);
        chk("R5 exec_valid after reset", {31'b0, exec_valid}, 32'd0);
        chk("R10 dout_oe idle", {31'b0, dout_oe}, 32'd0);
        read_both("reset");

        for (int i = 0; i < NV; i++) begin
            match_ref = VECS[i].rf; match_mask = VECS[i].mk; mem_spare = VECS[i].spare;
            for (int b = 0; b < int'(VECS[i].nb); b++)
                do_write(1'b0, VECS[i].bytes[31-8*b -: 8], 1'b1, 3);
            do_write(1'b1, VECS[i].op, 1'b1, 0);
            wait_exec(lat);
            // R7 latency, R2/R3 no request
            chk($sformatf("R7 latency vec%0d", i), lat, {28'b0, VECS[i].lat});
            if (VECS[i].ex) begin
                chk($sformatf("R4 R5 R6 exec_op vec%0d", i), {29'b0, cap_op}, {29'b0, VECS[i].eop});
                chk($sformatf("R5 exec_data vec%0d", i), cap_data, VECS[i].bytes);
                m_or1 = {5'b0, VECS[i].eop}; m_or2 = VECS[i].bytes[31:24];
            end
            chk($sformatf("R2 R3 R8 dr vec%0d", i), {31'b0, dr}, {31'b0, VECS[i].edr});
            s0 = n_step;
            read_both($sformatf("vec%0d", i));
            chk($sformatf("R10 steps vec%0d", i), n_step - s0, 32'd2);
        end

        // R10 repeated reads
        mem_spare = 1'b1; match_mask = 8'h00;
        s0 = n_step;
        do_read(1'b1, v, oe, 4);
        do_read(1'b0, v, oe, 4);
        do_read(1'b0, v, oe, 4);
        chk("R10 repeated reads step once", n_step - s0, 32'd1);

        // R11 write inside hold window after OR2 read is dropped
        do_read(1'b1, v, oe, 0);
        do_write(1'b0, 8'hC1, 1'b1, 4);
        do_write(1'b0, 8'hC2, 1'b1, 3);
        do_write(1'b0, 8'hC3, 1'b1, 3);
        do_write(1'b1, 8'h05, 1'b1, 0);
        wait_exec(lat);
        chk("R11 hold write ignored latency", lat, 32'd6);
        chk("R11 hold write ignored data", cap_data, 32'hC2C30000);

        // R12 deselected write is dropped
        do_write(1'b0, 8'hDD, 1'b0, 3);
        do_write(1'b0, 8'hD1, 1'b1, 3);
        do_write(1'b0, 8'hD2, 1'b1, 3);
        do_write(1'b1, 8'h05, 1'b1, 0);
        wait_exec(lat);
        chk("R12 deselected write ignored", cap_data, 32'hD1D20000);

        // R13 write while busy is dropped
        mem_spare = 1'b0;
        do_write(1'b0, 8'hE1, 1'b1, 3);
        do_write(1'b0, 8'hE2, 1'b1, 3);
        e0 = n_exec;
        do_write(1'b1, 8'h05, 1'b1, 0);
        do_write(1'b0, 8'h99, 1'b1, 14);
        chk("R13 busy instruction executed", n_exec - e0, 32'd1);
        mem_spare = 1'b1;
        do_write(1'b0, 8'hF1, 1'b1, 3);
        do_write(1'b0, 8'hF2, 1'b1, 3);
        do_write(1'b1, 8'h05, 1'b1, 0);
        wait_exec(lat);
        chk("R13 busy write ignored", cap_data, 32'hF1F20000);
        chk("R8 dr after execution", {31'b0, dr}, 32'd1);

        // R9 overlapping strobes
        do_write(1'b0, 8'hB1, 1'b1, 3);
        s0 = n_step;
        @(negedge clk); cd = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        din = 8'hB2; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 bus released on conflict", {31'b0, dout_oe}, 32'd0);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 conflicted read no step", n_step - s0, 32'd0);
        do_write(1'b1, 8'h05, 1'b1, 0);
        wait_exec(lat);
        chk("R9 conflicted write ignored", lat, 32'd0);
        chk("R9 R2 dr low after count error", {31'b0, dr}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule